// File: doc/BRIEF.md
# Quad-Channel Digital Potentiometer Serial Command Front End

This block is the serial command decoder for a four-channel, 256-step digital potentiometer. An external host drives a chip-select, a serial clock and a data line. The block brings all three into the system clock domain and collects 24-bit command frames. When chip-select returns high, it executes the frame. The frame updates one of four wiper (tap) registers, one of four output-buffer mode bits, or one of four shadow slots that stand in for nonvolatile memory. A frame can also ask for a wiper value to be shifted back on the serial output during the following frame.

Writes that would program nonvolatile cells are modelled by a busy interval of fixed length. A ready output is held low for that interval, and any frame that begins while the block is busy is dropped. The buffer-mode bit never goes directly to the output mux. It is first written into a shadow slot, and a separate load command copies that slot into a channel.

Top module: `dpot_spi_ctrl`

## Requirements
- R1: After reset every tap is 0x80 (RESET_TAP), every mode bit is 0 (buffer off), `ready_o` is 1 and `spi_miso` is 0.
- R2: A frame is 24 bits, sent MSB first and sampled on rising SCLK. Bits 23:20 hold the opcode, 19:18 the slot number, 17:16 the channel number, 15:9 are ignored, bit 8 holds the mode and bits 7:0 the tap. The frame executes when chip-select goes high.
- R3: If the bit count between chip-select going low and going high is zero or is not a multiple of 24, nothing happens. For a larger multiple of 24, only the last 24 bits are executed.
- R4: Opcode 1 writes bits 7:0 into the tap of channel 17:16 (00→0, 01→1, 10→2, 11→3). The mode bits do not change.
- R5: Opcode 2 stores {bit 8, bits 7:0} into slot 19:18. No tap or mode output changes.
- R6: Opcode 6 copies slot 19:18 into channel 17:16, both tap and mode. A mode bit of 1 means buffer on.
- R7: After opcode 3 for channel c, the next frame shifts out {15 zeros, mode[c], tap[c]} on `spi_miso`, MSB first, advancing on falling SCLK. At all other times the output shifts zeros.
- R8: Opcodes 2, 4, 5, 6 and 7 pull `ready_o` low for exactly BUSY_CYCLES clocks. Opcodes 0, 1, 3 and 8–15 leave it high.
- R9: A frame whose chip-select falls while `ready_o` is low is ignored in full. `spi_miso` holds its value while busy.
- R10: Opcodes 0, 4, 5, 7 and 8–15 change no tap, mode or slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip-select, active low, asynchronous |
| spi_sclk | input | 1 | Serial clock, asynchronous |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| ready_o | output | 1 | High when ready, low during the programming interval |
| tap_o | output | 32 | Four 8-bit wiper positions, channel 0 in bits 7:0 |
| mode_o | output | 4 | Buffer-on bit per channel |

## Verification
The hardest case to reach is a frame that begins inside the busy window. The stimulus sends a slot write, watches `ready_o` until it falls, and only then lowers chip-select for a tap write. That tap write must leave no trace, and a later load must show that the slot write still happened. A second hard case is the readback, which spans two frames. An opcode 3 frame arms it, and the returned word is captured bit by bit on rising SCLK during the next frame and compared as a whole. A third frame must then return zeros. The length check is driven with 0, 23, 25 and 48 bits.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
    localparam int FRAME_W = 24;
    localparam int TAP_W   = 8;
    localparam int N_CH    = 4;
    localparam int N_SLOT  = 4;
    localparam int SEL_W   = $clog2(N_CH);
    localparam int CNT_W   = $clog2(FRAME_W);

    // field positions inside the 24-bit word
    localparam int OP_HI   = 23;
    localparam int SLOT_HI = 19;
    localparam int CH_HI   = 17;
    localparam int MODE_B  = 8;

    typedef enum logic [3:0] {
        OP_NOP       = 4'd0,
        OP_SET_TAP   = 4'd1,
        OP_STORE     = 4'd2,
        OP_READ_TAP  = 4'd3,
        OP_PROG_A    = 4'd4,
        OP_PROG_B    = 4'd5,
        OP_LOAD      = 4'd6,
        OP_PROG_C    = 4'd7
    } op_e;

    typedef struct packed {
        logic             mode;
        logic [TAP_W-1:0] tap;
    } chan_t;

    function automatic logic op_needs_busy(input logic [3:0] op);
        return (op == OP_STORE) || (op == OP_PROG_A) || (op == OP_PROG_B) ||
               (op == OP_LOAD)  || (op == OP_PROG_C);
    endfunction
endpackage

// File: rtl/dpot_sync.sv
module dpot_sync #(
    parameter int           W    = 3,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s1: INIT, s2: INIT, s3: INIT};
        else        st_q <= st_d;
    end

    for (genvar gi = 0; gi < W; gi++) begin : g_edge
        assign level_o[gi] = st_q.s2[gi];
        assign rise_o[gi]  = st_q.s2[gi] & ~st_q.s3[gi];
        assign fall_o[gi]  = ~st_q.s2[gi] & st_q.s3[gi];
    end
endmodule

// File: rtl/dpot_frame.sv
module dpot_frame
    import dpot_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_level,
    input  logic               cs_fall,
    input  logic               cs_rise,
    input  logic               sclk_rise,
    input  logic               mosi,
    input  logic               busy,
    output logic               frame_ok_o,
    output logic [FRAME_W-1:0] word_o,
    output logic               skip_o
);
    typedef struct packed {
        logic [FRAME_W-1:0] shift;
        logic [CNT_W-1:0]   cnt;
        logic               seen;
        logic               skip;
        logic               ok;
    } frm_t;

    frm_t fr_d, fr_q;

    always_comb begin
        fr_d    = fr_q;
        fr_d.ok = 1'b0;
        if (cs_fall) begin
            fr_d.cnt  = '0;
            fr_d.seen = 1'b0;
            fr_d.skip = busy;
        end else if (sclk_rise && !cs_level && !fr_q.skip) begin
            fr_d.shift = {fr_q.shift[FRAME_W-2:0], mosi};
            fr_d.cnt   = (fr_q.cnt == CNT_W'(FRAME_W-1)) ? '0 : fr_q.cnt + 1'b1;
            fr_d.seen  = 1'b1;
        end
        if (cs_rise) begin
            fr_d.ok   = fr_q.seen && !fr_q.skip && (fr_q.cnt == '0);
            fr_d.seen = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    assign frame_ok_o = fr_q.ok;
    assign word_o     = fr_q.shift;
    assign skip_o     = fr_q.skip;
endmodule

// File: rtl/dpot_busy.sv
module dpot_busy #(
    parameter int CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic ready_o
);
    localparam int BW = $clog2(CYC + 1);

    logic [BW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)            cnt_d = BW'(CYC);
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign ready_o = (cnt_q == '0);
endmodule

// File: rtl/dpot_spi_ctrl.sv
module dpot_spi_ctrl
    import dpot_pkg::*;
#(
    parameter int               BUSY_CYCLES = 1000,
    parameter logic [TAP_W-1:0] RESET_TAP   = 8'h80
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    spi_cs_n,
    input  logic                    spi_sclk,
    input  logic                    spi_mosi,
    output logic                    spi_miso,
    output logic                    ready_o,
    output logic [N_CH*TAP_W-1:0]   tap_o,
    output logic [N_CH-1:0]         mode_o
);
    typedef struct packed {
        chan_t [N_CH-1:0]   ch;
        chan_t [N_SLOT-1:0] slot;
        logic [FRAME_W-1:0] tx;
    } core_t;

    logic [2:0] lvl, rise, fall;
    logic               frame_ok, frame_skip, busy_start;
    logic [FRAME_W-1:0] frame_word;
    logic [3:0]         op;
    logic [SEL_W-1:0]   ch_sel, slot_sel;
    chan_t              wr_val;
    core_t              st_d, st_q;

    // bit 0 chip-select, bit 1 serial clock, bit 2 data in
    dpot_sync #(.W(3), .INIT(3'b001)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({spi_mosi, spi_sclk, spi_cs_n}),
        .level_o (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    dpot_frame u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_level   (lvl[0]),
        .cs_fall    (fall[0]),
        .cs_rise    (rise[0]),
        .sclk_rise  (rise[1]),
        .mosi       (lvl[2]),
        .busy       (!ready_o),
        .frame_ok_o (frame_ok),
        .word_o     (frame_word),
        .skip_o     (frame_skip)
    );

    assign op       = frame_word[OP_HI -: 4];
    assign slot_sel = frame_word[SLOT_HI -: SEL_W];
    assign ch_sel   = frame_word[CH_HI -: SEL_W];
    assign wr_val   = '{mode: frame_word[MODE_B], tap: frame_word[TAP_W-1:0]};
    assign busy_start = frame_ok && op_needs_busy(op);

    dpot_busy #(.CYC(BUSY_CYCLES)) u_busy (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (busy_start),
        .ready_o (ready_o)
    );

    function automatic core_t reset_state();
        core_t r;
        r = '0;
        for (int i = 0; i < N_CH; i++) begin
            r.ch[i].mode = 1'b0;
            r.ch[i].tap  = RESET_TAP;
        end
        return r;
    endfunction

    always_comb begin
        st_d = st_q;
        if (rise[0])
            st_d.tx = '0;
        else if (fall[1] && !lvl[0] && ready_o && !frame_skip)
            st_d.tx = {st_q.tx[FRAME_W-2:0], 1'b0};
        if (frame_ok) begin
            case (op)
                OP_SET_TAP:  st_d.ch[ch_sel].tap = wr_val.tap;
                OP_STORE:    st_d.slot[slot_sel] = wr_val;
                OP_LOAD:     st_d.ch[ch_sel]     = st_q.slot[slot_sel];
                OP_READ_TAP: st_d.tx = {{(FRAME_W-TAP_W-1){1'b0}}, st_q.ch[ch_sel]};
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end

    for (genvar gi = 0; gi < N_CH; gi++) begin : g_out
        assign tap_o[gi*TAP_W +: TAP_W] = st_q.ch[gi].tap;
        assign mode_o[gi]               = st_q.ch[gi].mode;
    end

    assign spi_miso = st_q.tx[FRAME_W-1];
endmodule

// File: rtl/dpot_spi_ctrl_chk.sv
module dpot_spi_ctrl_chk
    import dpot_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  frame_ok,
    input logic [FRAME_W-1:0]    frame_word,
    input logic                  ready,
    input logic                  miso,
    input logic [N_CH*TAP_W-1:0] tap,
    input logic [N_CH-1:0]       mode
);
    AST_OUTPUTS_HOLD_WITHOUT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_ok |=> ($stable(tap) && $stable(mode))); // R10

    AST_BUSY_FOLLOWS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(frame_ok)); // R8

    AST_QUIET_OPS_STAY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ok && !op_needs_busy(frame_word[OP_HI -: 4])) |=> ready); // R8

    AST_NO_EXEC_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !frame_ok); // R9

    AST_MISO_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && $past(!ready)) |-> $stable(miso)); // R9
endmodule

bind dpot_spi_ctrl dpot_spi_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_ok   (frame_ok),
    .frame_word (frame_word),
    .ready      (ready_o),
    .miso       (spi_miso),
    .tap        (tap_o),
    .mode       (mode_o)
);

// File: tb/dpot_spi_ctrl_test.sv
`timescale 1ns/1ps
module dpot_spi_ctrl_test;
    localparam int BUSY = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
    logic        miso, ready;
    logic [31:0] taps;
    logic [3:0]  modes;

    int          n_cmp = 0, n_bad = 0;
    logic [47:0] rx_word;
    int          busy_len;
    bit          done = 0;

    typedef struct {
        int          kind;   // 0 tap, 1 mode, 2 ready, 3 rx word, 4 busy length, 5 miso
        int          idx;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sbq[$];

    dpot_spi_ctrl #(.BUSY_CYCLES(BUSY), .RESET_TAP(8'h80)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_cs_n (cs_n),
        .spi_sclk (sclk),
        .spi_mosi (mosi),
        .spi_miso (miso),
        .ready_o  (ready),
        .tap_o    (taps),
        .mode_o   (modes)
    );

    always #2.5 clk = ~clk;

    function automatic logic [23:0] mk(input logic [3:0] op, input logic [1:0] sl,
                                       input logic [1:0] ch, input logic md,
                                       input logic [7:0] tp);
        return {op, sl, ch, 7'b1010101, md, tp};
    endfunction

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            item_t it;
            logic [31:0] act;
            wait (sbq.size() > 0);
            it = sbq.pop_front();
            case (it.kind)
                0: act = {24'd0, taps[it.idx*8 +: 8]};
                1: act = {31'd0, modes[it.idx]};
                2: act = {31'd0, ready};
                3: act = rx_word[31:0];
                4: act = busy_len;
                default: act = {31'd0, miso};
            endcase
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h",
                         it.tag, it.kind, it.idx, act, it.exp);
            end
        end
    end

    task automatic expect_item(input int kind, input int idx, input logic [31:0] exp,
                               input string tag);
        item_t it;
        it.kind = kind; it.idx = idx; it.exp = exp; it.tag = tag;
        sbq.push_back(it);
        wait (sbq.size() == 0);
        #0;
    endtask

    task automatic xfer(input logic [47:0] w, input int nbits);
        rx_word = '0;
        @(negedge clk); cs_n = 1'b0;
        repeat (10) @(negedge clk);
        for (int i = nbits - 1; i >= 0; i--) begin
            mosi = w[i];
            repeat (8) @(negedge clk);
            rx_word = {rx_word[46:0], miso};
            sclk = 1'b1;
            repeat (8) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (8) @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic measure_busy();
        int guard = 0;
        busy_len = 0;
        while (ready && guard < 12) begin @(negedge clk); guard++; end
        while (!ready) begin busy_len++; @(negedge clk); end
        repeat (4) @(negedge clk);
    endtask

    task automatic cmd(input logic [23:0] w);
        xfer({24'd0, w}, 24);
        measure_busy();
    endtask

    task automatic check_taps(input logic [7:0] t0, input logic [7:0] t1,
                              input logic [7:0] t2, input logic [7:0] t3, input string tag);
        expect_item(0, 0, {24'd0, t0}, tag);
        expect_item(0, 1, {24'd0, t1}, tag);
        expect_item(0, 2, {24'd0, t2}, tag);
        expect_item(0, 3, {24'd0, t3}, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state
        check_taps(8'h80, 8'h80, 8'h80, 8'h80, "R1 reset tap");
        for (int c = 0; c < 4; c++) expect_item(1, c, 0, "R1 reset mode");
        expect_item(2, 0, 1, "R1 reset ready");
        expect_item(5, 0, 0, "R1 reset miso");

        // R4 / R2 direct tap writes, no busy (R8)
        cmd(mk(4'd1, 2'd3, 2'd0, 1'b1, 8'h12));
        expect_item(4, 0, 0, "R8 opcode 1 no busy");
        cmd(mk(4'd1, 2'd0, 2'd3, 1'b0, 8'hF0));
        check_taps(8'h12, 8'h80, 8'h80, 8'hF0, "R4 R2 tap write");
        expect_item(1, 0, 0, "R4 mode untouched");

        // R3 length rules
        xfer({24'd0, mk(4'd1, 2'd0, 2'd1, 1'b0, 8'h11)} >> 1, 23); measure_busy();
        xfer({23'd0, mk(4'd1, 2'd0, 2'd1, 1'b0, 8'h11), 1'b1}, 25); measure_busy();
        xfer(48'd0, 0); measure_busy();
        expect_item(0, 1, 32'h80, "R3 bad length ignored");
        xfer({mk(4'd1, 2'd0, 2'd1, 1'b0, 8'h11), mk(4'd1, 2'd0, 2'd1, 1'b0, 8'h77)}, 48);
        measure_busy();
        expect_item(0, 1, 32'h77, "R3 last of two frames");

        // R5 slot store
        cmd(mk(4'd2, 2'd2, 2'd0, 1'b1, 8'hA5));
        expect_item(4, 0, BUSY, "R8 opcode 2 busy length");
        check_taps(8'h12, 8'h77, 8'h80, 8'hF0, "R5 store invisible");
        expect_item(1, 2, 0, "R5 mode invisible");

        // R6 load slot into channel 2
        cmd(mk(4'd6, 2'd2, 2'd2, 1'b0, 8'h00));
        expect_item(4, 0, BUSY, "R8 opcode 6 busy length");
        expect_item(0, 2, 32'hA5, "R6 load tap");
        expect_item(1, 2, 1, "R6 load mode");

        // R7 readback
        cmd(mk(4'd3, 2'd0, 2'd2, 1'b0, 8'h00));
        expect_item(4, 0, 0, "R8 opcode 3 no busy");
        cmd(mk(4'd0, 2'd0, 2'd0, 1'b0, 8'h00));
        expect_item(3, 0, 32'h000001A5, "R7 readback word");
        cmd(mk(4'd0, 2'd0, 2'd0, 1'b0, 8'h00));
        expect_item(3, 0, 32'h0, "R7 zeros after readback");

        // R10 / R8 programming-only and unused opcodes
        cmd(mk(4'd4, 2'd1, 2'd1, 1'b1, 8'h55));
        expect_item(4, 0, BUSY, "R8 opcode 4 busy length");
        cmd(mk(4'd5, 2'd1, 2'd1, 1'b1, 8'h55));
        expect_item(4, 0, BUSY, "R8 opcode 5 busy length");
        cmd(mk(4'd7, 2'd1, 2'd1, 1'b1, 8'h55));
        expect_item(4, 0, BUSY, "R8 opcode 7 busy length");
        cmd(mk(4'd9, 2'd1, 2'd1, 1'b1, 8'h55));
        expect_item(4, 0, 0, "R8 opcode 9 no busy");
        check_taps(8'h12, 8'h77, 8'hA5, 8'hF0, "R10 no effect");
        for (int c = 0; c < 4; c++)
            expect_item(1, c, (c == 2) ? 1 : 0, "R10 modes unchanged");
        cmd(mk(4'd6, 2'd1, 2'd1, 1'b0, 8'h00));
        expect_item(0, 1, 32'h0, "R10 slot 1 untouched");

        // R9 frame started during busy is dropped
        xfer({24'd0, mk(4'd2, 2'd0, 2'd0, 1'b1, 8'h33)}, 24);
        while (ready) @(negedge clk);
        xfer({24'd0, mk(4'd1, 2'd0, 2'd0, 1'b0, 8'h44)}, 24);
        measure_busy();
        expect_item(0, 0, 32'h12, "R9 busy frame ignored");
        cmd(mk(4'd6, 2'd0, 2'd0, 1'b0, 8'h00));
        expect_item(0, 0, 32'h33, "R9 prior store kept");
        expect_item(1, 0, 1, "R9 prior store mode");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule